// File: doc/BRIEF.md
# Generated-Bits Word Readout Path

This block sits between a random-bit generator that produces 128-bit output units and a 32-bit register interface. Each unit arrives with a compliance flag on a valid/ready handshake and goes into a small internal buffer. Software drains the buffer through a read-only data register. Every access to that register raises a read strobe, and the strobe pops one 32-bit word. A status pair tells the reader whether words are waiting and whether the unit being drained carries the compliance mark.

One unit is fully consumed by four data reads. A request for N units therefore takes 4N reads. After the fourth read of a unit, the next buffered unit takes its place in the same clock. All outputs are registers. They are loaded from the next state of the buffer and word pointer, so the value for the next read is ready in the cycle after each strobe.

Top module: `genbits_readout`

## Requirements
- R1: Synchronous reset sets word_data to 0, stat_avail and stat_compliant to 0, and blk_ready to 1.
- R2: A unit is accepted on a clock edge where blk_valid and blk_ready are both 1. blk_ready is 0 while two units are held. It returns to 1 in the cycle after the fourth read of the current unit.
- R3: stat_avail (status bit 0) is 1 from the cycle after the first unit is accepted, for as long as any unit is held.
- R4: A unit's words are presented least-significant first. Word k (k = 0..3) is blk_data[32k+31:32k].
- R5: A read strobe while stat_avail is 1 presents the next word in the following cycle. Without a strobe, word_data and the status bits hold.
- R6: After the fourth strobe on a unit, that unit is released. The following cycle shows word 0 of the next held unit, or stat_avail = 0 when none is held.
- R7: stat_compliant (status bit 1) equals the compliance flag of the unit currently presented. It is 0 when none is presented.
- R8: A strobe while stat_avail is 0 leaves word_data at 0 and does not move the word pointer. The next unit still starts at word 0.
- R9: If a new unit is accepted in the same cycle as the fourth strobe on the only held unit, the new unit's word 0 appears in the next cycle with no empty gap.
- R10: A sequence of N accepted units is drained by exactly 4N effective reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_valid | input | 1 | Generator offers a unit |
| blk_ready | output | 1 | Buffer can take a unit |
| blk_data | input | 128 | Generated unit |
| blk_compliant | input | 1 | Compliance flag of the offered unit |
| word_rd | input | 1 | Read strobe of the data register (pops a word) |
| word_data | output | 32 | Current 32-bit word, 0 when empty |
| stat_avail | output | 1 | Status bit 0: words available |
| stat_compliant | output | 1 | Status bit 1: current unit is compliance-marked |

## Verification
Every result is due exactly one clock after the edge that samples its cause. An accept makes stat_avail and word 0 visible one cycle later. A strobe shows the next word, or the next unit, one cycle later. blk_ready follows occupancy one cycle after an accept or a release. The bench drives inputs at the falling edge. It updates its own queue model at the rising edge and compares all outputs 1 ns after that edge, so each check lands in the first cycle where the result is due. Sweeps over one to four units, with irregular strobe patterns, check the 4N read count and the hand-over between units.

// File: rtl/genbits_pkg.sv
package genbits_pkg;
  // Default geometry of the readout path
  localparam int BLK_W_DEF  = 128;
  localparam int WORD_W_DEF = 32;
  localparam int DEPTH_DEF  = 2;

  // Number of bits needed to index 'n' items (at least 1)
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/genbits_buf.sv
// Small FIFO of generated units; storage is written without reset so it can
// map onto RAM, and the next head entry is produced for the output stage.
module genbits_buf #(
  parameter int ENT_W = 129,
  parameter int DEPTH = 2,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [ENT_W-1:0] din,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic [ENT_W-1:0] head_d
);
  localparam int PTR_W = genbits_pkg::idx_bits(DEPTH);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] after_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    rd_d      = pop  ? ptr_inc(rd_q) : rd_q;
    wr_d      = push ? ptr_inc(wr_q) : wr_q;
    after_pop = cnt_q - CNT_W'(pop);
    cnt_d     = after_pop + CNT_W'(push);
    // bypass: a write into an empty (or emptying) buffer becomes the head
    if (push && (after_pop == '0)) head_d = din;
    else                           head_d = mem[rd_d];
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/genbits_wordsel.sv
// Word pointer within the current unit; produces the release pulse.
module genbits_wordsel #(
  parameter int WORDS = 4,
  parameter int WP_W  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd,
  input  logic            avail,
  output logic [WP_W-1:0] wp_d,
  output logic            release_unit
);
  logic [WP_W-1:0] wp_q;
  logic            take, at_last;

  always_comb begin
    take         = rd && avail;
    at_last      = (wp_q == WP_W'(WORDS - 1));
    release_unit = take && at_last;
    if (!take)       wp_d = wp_q;
    else if (at_last) wp_d = '0;
    else              wp_d = wp_q + WP_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) wp_q <= '0;
    else     wp_q <= wp_d;
  end
endmodule

// File: rtl/genbits_outstage.sv
// Registered outputs computed from the next state of buffer and pointer.
module genbits_outstage #(
  parameter int BLK_W  = 128,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int WP_W   = 2,
  parameter int CNT_W  = 2,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BLK_W:0]    head_d,
  input  logic [WP_W-1:0]   wp_d,
  input  logic [CNT_W-1:0]  cnt_d,
  output logic [WORD_W-1:0] word_data,
  output logic              stat_avail,
  output logic              stat_compliant,
  output logic              blk_ready
);
  logic [WORD_W-1:0] lane [WORDS];
  logic [WORD_W-1:0] sel_word;
  logic              any_d;

  for (genvar g = 0; g < WORDS; g++) begin : g_lane
    assign lane[g] = head_d[g*WORD_W +: WORD_W];
  end

  always_comb begin
    any_d    = (cnt_d != '0);
    sel_word = lane[wp_d];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_data      <= '0;
      stat_avail     <= 1'b0;
      stat_compliant <= 1'b0;
      blk_ready      <= 1'b1;
    end else begin
      word_data      <= any_d ? sel_word : '0;
      stat_avail     <= any_d;
      stat_compliant <= any_d && head_d[BLK_W];
      blk_ready      <= (cnt_d < CNT_W'(DEPTH));
    end
  end
endmodule

// File: rtl/genbits_readout.sv
module genbits_readout #(
  parameter int BLK_W  = genbits_pkg::BLK_W_DEF,
  parameter int WORD_W = genbits_pkg::WORD_W_DEF,
  parameter int DEPTH  = genbits_pkg::DEPTH_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blk_valid,
  output logic              blk_ready,
  input  logic [BLK_W-1:0]  blk_data,
  input  logic              blk_compliant,
  input  logic              word_rd,
  output logic [WORD_W-1:0] word_data,
  output logic              stat_avail,
  output logic              stat_compliant
);
  localparam int WORDS = BLK_W / WORD_W;
  localparam int WP_W  = genbits_pkg::idx_bits(WORDS);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = BLK_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ENT_W-1:0] head_d;
  logic [WP_W-1:0]  wp_d;
  logic             push, release_unit, held;

  assign held = (cnt_q != '0);
  assign push = blk_valid && (cnt_q < CNT_W'(DEPTH));

  genbits_buf #(.ENT_W(ENT_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_buf (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .pop   (release_unit),
    .din   ({blk_compliant, blk_data}),
    .cnt_q (cnt_q),
    .cnt_d (cnt_d),
    .head_d(head_d)
  );

  genbits_wordsel #(.WORDS(WORDS), .WP_W(WP_W)) u_sel (
    .clk         (clk),
    .rst         (rst),
    .rd          (word_rd),
    .avail       (held),
    .wp_d        (wp_d),
    .release_unit(release_unit)
  );

  genbits_outstage #(
    .BLK_W(BLK_W), .WORD_W(WORD_W), .WORDS(WORDS),
    .WP_W(WP_W), .CNT_W(CNT_W), .DEPTH(DEPTH)
  ) u_out (
    .clk           (clk),
    .rst           (rst),
    .head_d        (head_d),
    .wp_d          (wp_d),
    .cnt_d         (cnt_d),
    .word_data     (word_data),
    .stat_avail    (stat_avail),
    .stat_compliant(stat_compliant),
    .blk_ready     (blk_ready)
  );
endmodule

// File: rtl/genbits_readout_chk.sv
module genbits_readout_chk #(
  parameter int BLK_W  = 128,
  parameter int WORD_W = 32,
  parameter int DEPTH  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              blk_valid,
  input logic              blk_ready,
  input logic              word_rd,
  input logic [WORD_W-1:0] word_data,
  input logic              stat_avail,
  input logic              stat_compliant
);
  localparam int WORDS = BLK_W / WORD_W;

  int occ;
  int rdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ <= 0;
      rdc <= 0;
    end else begin
      if (word_rd && stat_avail && rdc == WORDS - 1) begin
        rdc <= 0;
        occ <= occ - 1 + ((blk_valid && blk_ready) ? 1 : 0);
      end else begin
        if (word_rd && stat_avail) rdc <= rdc + 1;
        occ <= occ + ((blk_valid && blk_ready) ? 1 : 0);
      end
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!stat_avail && !stat_compliant && word_data == '0 && blk_ready));

  // R2
  ready_level_chk: assert property (@(posedge clk) disable iff (rst)
    blk_ready == (occ < DEPTH));

  // R3
  avail_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && blk_ready) |=> stat_avail);

  // R6
  avail_level_chk: assert property (@(posedge clk) disable iff (rst)
    stat_avail == (occ != 0));

  // R5
  hold_without_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!word_rd && stat_avail) |=> (stat_avail && $stable(word_data) && $stable(stat_compliant)));

  // R8
  empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !stat_avail |-> (word_data == '0 && !stat_compliant));
endmodule

bind genbits_readout genbits_readout_chk #(.BLK_W(BLK_W), .WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .blk_valid     (blk_valid),
  .blk_ready     (blk_ready),
  .word_rd       (word_rd),
  .word_data     (word_data),
  .stat_avail    (stat_avail),
  .stat_compliant(stat_compliant)
);

// File: tb/sim_genbits_readout.sv
`timescale 1ns/1ps
module sim_genbits_readout;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         blk_valid = 1'b0;
  logic         blk_ready;
  logic [127:0] blk_data = '0;
  logic         blk_compliant = 1'b0;
  logic         word_rd = 1'b0;
  logic [31:0]  word_data;
  logic         stat_avail;
  logic         stat_compliant;

  int total = 0;
  int bad   = 0;

  logic [128:0] q[$];
  int           wp = 0;

  always #2 clk = ~clk;

  genbits_readout u0 (
    .clk(clk), .rst(rst), .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_data(blk_data), .blk_compliant(blk_compliant), .word_rd(word_rd),
    .word_data(word_data), .stat_avail(stat_avail), .stat_compliant(stat_compliant)
  );

  function automatic logic [127:0] mk(input int b);
    logic [127:0] v;
    for (int k = 0; k < 4; k++)
      v[k*32 +: 32] = {8'(b), 8'(k + 1), 16'hC3A5 ^ 16'(b * 37 + k * 11)};
    return v;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [31:0] ed;
    logic [2:0]  ef;
    ed = (q.size() > 0) ? q[0][wp*32 +: 32] : 32'h0;
    ef = {q.size() < 2, q.size() > 0, (q.size() > 0) ? q[0][128] : 1'b0};
    chk(word_data == ed, tag, word_data, ed);
    chk({blk_ready, stat_avail, stat_compliant} == ef, tag,
        {29'h0, blk_ready, stat_avail, stat_compliant}, {29'h0, ef});
  endtask

  task automatic step(input logic v, input logic [127:0] d, input logic c, input logic r, input string tag);
    logic acc;
    @(negedge clk);
    blk_valid = v; blk_data = d; blk_compliant = c; word_rd = r;
    @(posedge clk);
    acc = v && (q.size() < 2);
    if (r && q.size() > 0) begin
      if (wp == 3) begin wp = 0; void'(q.pop_front()); end
      else wp++;
    end
    if (acc) q.push_back({c, d});
    #1;
    check_all(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check_all("R1 reset state");

    // R8: strobes on empty buffer
    step(0, '0, 0, 1, "R8 empty read");
    step(0, '0, 0, 1, "R8 empty read");
    // R3/R4/R7: first unit, compliant
    step(1, mk(1), 1, 0, "R3 accept");
    chk(word_data == mk(1)[31:0], "R8 pointer unmoved/R4 word0", word_data, mk(1)[31:0]);
    // R2: second unit fills buffer
    step(1, mk(2), 0, 0, "R2 fill");
    chk(!blk_ready, "R2 ready low when full", {31'h0, blk_ready}, 32'h0);
    step(1, mk(3), 1, 0, "R2 offer while full ignored");
    // R4/R5 with gaps
    for (int k = 0; k < 4; k++) begin
      step(0, '0, 0, 1, "R4 R5 word order");
      step(0, '0, 0, 0, "R5 hold");
    end
    chk(word_data == mk(2)[31:0] && !stat_compliant, "R6 R7 next unit",
        word_data, mk(2)[31:0]);
    chk(blk_ready, "R2 ready after release", {31'h0, blk_ready}, 32'h1);
    // drain second unit back to back
    for (int k = 0; k < 4; k++) step(0, '0, 0, 1, "R6 drain");
    chk(!stat_avail, "R6 empty after drain", {31'h0, stat_avail}, 32'h0);
    // R9: accept in the same cycle as final strobe
    step(1, mk(4), 0, 0, "R9 load");
    for (int k = 0; k < 3; k++) step(0, '0, 0, 1, "R9 read");
    step(1, mk(5), 1, 1, "R9 overlap");
    chk(stat_avail && stat_compliant && word_data == mk(5)[31:0], "R9 no gap",
        word_data, mk(5)[31:0]);
    for (int k = 0; k < 4; k++) step(0, '0, 0, 1, "R9 drain");

    // R10: sweep unit counts and strobe patterns
    for (int n = 1; n <= 4; n++) begin
      for (int pat = 0; pat < 3; pat++) begin
        int pushed = 0;
        int reads  = 0;
        for (int cyc = 0; cyc < 300; cyc++) begin
          logic v, r;
          v = (pushed < n);
          r = ((cyc + pat) % 3) != 1;
          if (r && q.size() > 0) reads++;
          if (v && q.size() < 2) pushed++;
          step(v, mk(16 * n + 4 * pat + pushed), 1'((n + pushed) % 2), r, "R10 sweep");
          if (pushed == n && q.size() == 0) break;
        end
        chk(reads == 4 * n, "R10 reads per units", 32'(reads), 32'(4 * n));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule